// File: doc/BRIEF.md
# I2C target byte engine

This block is the target side of an I2C bus port. It watches the bus for a START, shifts in the 7-bit address with its direction bit, and compares the address against a programmed value. Traffic for other addresses passes without an acknowledge, a flag or a held clock. On a match the engine acknowledges the address. It then hands the complete address byte, including the R/W bit, to software in the same way as any received byte. Software services the engine one byte at a time through a small set of sticky interrupt flags.

When the controller writes, each byte is acknowledged and posted with the received-byte flag. After the acknowledge bit the engine holds SCL low until software clears that flag. When the controller reads, the engine holds SCL low after every acknowledge until software supplies a byte with a transmit command. The byte is then shifted out MSB first, and the controller's acknowledge is reported as an ACK or NAK flag. A NAK ends the read. A STOP after an addressed transfer raises its own flag. A repeated START begins address matching again.

Both bus inputs are resynchronised and glitch-filtered before START and STOP are detected. START and STOP are SDA edges while SCL is high. The drive outputs are open-drain enables: a 1 pulls the line low.

Top module: `i2c_tgt_engine`

## Requirements
- R1: When enabled, a START followed by an address byte whose bits [7:1] equal `own_addr_i` is acknowledged: SDA is pulled low during the ninth clock. Flag bit 7 (address match) and flag bit 2 (byte received) are set, and `rx_data_o` holds the whole byte, with R/W in bit 0.
- R2: An address byte that does not match gets no acknowledge, sets no flag and causes no SCL hold. The same holds for the rest of the transfer and for the STOP that ends it.
- R3: In write direction (R/W = 0), each following byte is acknowledged, sets flag bit 2, and is placed in `rx_data_o`.
- R4: After the acknowledge of a received byte, SCL is held low while flag bit 2 is still set. SCL is released once software clears that flag.
- R5: In read direction (R/W = 1), SCL is held low after every acknowledge until a `tx_cmd_i` pulse loads `tx_data_i`. That byte is then driven MSB first, one bit for each SCL low phase.
- R6: After each transmitted byte, flag bit 0 is set if the controller drove SDA low in the ninth clock, and flag bit 1 is set otherwise. After a NAK the engine releases SDA and no longer holds SCL.
- R7: A STOP (SDA rising while SCL is high) that ends a transfer in which the address matched sets flag bit 4.
- R8: A repeated START at any point discards the current transfer and restarts address matching.
- R9: While `tgt_en_i` is low, the engine never drives either line and sets no flag.
- R10: Writing a 1 to a bit of `sts_clr_i` clears only that flag. A flag set in the same cycle as its clear stays set. `irq_o` is high whenever any flag is set.
- R11: After reset all flags are clear and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tgt_en_i | input | 1 | Target function enable |
| own_addr_i | input | 7 | Programmed 7-bit target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock hold) |
| sda_oe_o | output | 1 | Pull SDA low (ACK or data 0) |
| tx_data_i | input | 8 | Byte to transmit in read direction |
| tx_cmd_i | input | 1 | One-cycle target-transmit command |
| sts_clr_i | input | 8 | Write-1-to-clear mask for the flags |
| sts_o | output | 8 | Flags: 0 TX ACK, 1 TX NAK, 2 RX done, 4 STOP, 7 address match |
| rx_data_o | output | 8 | Last received byte |
| irq_o | output | 1 | OR of all flags |

## Verification
A corrupted bit counter or shift register shows up at once as a wrong `rx_data_o`, or as an acknowledge placed in the wrong clock, and the byte-level checks catch it at that byte's ninth clock. A sequencer stuck in the wrong state shows up as an SCL hold that never releases, or that appears where none is due. This becomes visible within about one bit time through the bus-level hold checks and the bench's hang guard. Flag errors show up in `sts_o` right after the acknowledge bit of the byte that caused them. Sweeping all 128 addresses exposes any compare that is off by one bit.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned STS_W  = 8;

  localparam int unsigned F_TX_ACK  = 0;
  localparam int unsigned F_TX_NAK  = 1;
  localparam int unsigned F_RX_DONE = 2;
  localparam int unsigned F_STOP    = 4;
  localparam int unsigned F_MATCH   = 7;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_A_ACK,
    S_WR_WAIT,
    S_WR_BITS,
    S_W_ACK,
    S_RD_WAIT,
    S_RD_BITS,
    S_RD_ACK,
    S_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   q_q;
  logic                   s;

  assign s   = sync_q[SYNC_STAGES-1];
  assign q_o = q_q;

  // idle bus is high; output follows only after FILT_CYCLES stable samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      q_q    <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      if (s == q_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        q_q   <= s;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end

  assign start_o = scl_i & scl_p & sda_p & ~sda_i;
  assign stop_o  = scl_i & scl_p & ~sda_p & sda_i;
  assign rise_o  = scl_i & ~scl_p;
  assign fall_o  = ~scl_i & scl_p;
endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags
  import i2c_tgt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] clr_i,
  output logic [STS_W-1:0] sts_o
);
  logic [STS_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign sts_o = q;

  // R10: a flag only appears after a set event
  p_new_from_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_o & ~$past(sts_o)) & ~$past(set_i)) == '0);
  // R10: a cleared flag without a concurrent set is gone
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(clr_i) & ~$past(set_i)) & sts_o) == '0);
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_f_i,
  input  logic              sda_f_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              rx_pend_i,
  input  logic              tx_cmd_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [STS_W-1:0]  set_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              active_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, txb_q, rx_q;
  logic              txv_q, dir_q, act_q, nak_q, sda_oe_q, scl_oe_q;
  logic [STS_W-1:0]  set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      txb_q    <= '0;
      rx_q     <= '0;
      txv_q    <= 1'b0;
      dir_q    <= 1'b0;
      act_q    <= 1'b0;
      nak_q    <= 1'b0;
      sda_oe_q <= 1'b0;
      set_q    <= '0;
    end else begin
      set_q <= '0;
      if (!en_i) begin
        state_q  <= S_IDLE;
        sda_oe_q <= 1'b0;
        act_q    <= 1'b0;
        txv_q    <= 1'b0;
        cnt_q    <= '0;
      end else if (start_i) begin
        state_q  <= S_ADDR;
        sda_oe_q <= 1'b0;
        act_q    <= 1'b0;
        txv_q    <= 1'b0;
        cnt_q    <= '0;
      end else if (stop_i) begin
        if (act_q) set_q[F_STOP] <= 1'b1;
        state_q  <= S_IDLE;
        sda_oe_q <= 1'b0;
        act_q    <= 1'b0;
        txv_q    <= 1'b0;
      end else begin
        if (tx_cmd_i && act_q && dir_q) begin
          txv_q <= 1'b1;
          txb_q <= tx_data_i;
        end
        unique case (state_q)
          S_ADDR, S_WR_BITS: begin
            if (rise_i && cnt_q != CNT_FULL) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_f_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (fall_i && cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              if (state_q == S_WR_BITS) begin
                set_q[F_RX_DONE] <= 1'b1;
                rx_q     <= sh_q;
                sda_oe_q <= 1'b1;
                state_q  <= S_W_ACK;
              end else if (sh_q[BYTE_W-1:1] == own_addr_i) begin
                set_q[F_MATCH]   <= 1'b1;
                set_q[F_RX_DONE] <= 1'b1;
                rx_q     <= sh_q;
                dir_q    <= sh_q[0];
                act_q    <= 1'b1;
                sda_oe_q <= 1'b1;
                state_q  <= S_A_ACK;
              end else begin
                state_q <= S_IGNORE;
              end
            end
          end
          S_A_ACK: if (fall_i) begin
            sda_oe_q <= 1'b0;
            state_q  <= dir_q ? S_RD_WAIT : S_WR_WAIT;
          end
          S_W_ACK: if (fall_i) begin
            sda_oe_q <= 1'b0;
            state_q  <= S_WR_WAIT;
          end
          S_WR_WAIT: if (!rx_pend_i) begin
            cnt_q   <= '0;
            state_q <= S_WR_BITS;
          end
          S_RD_WAIT: if (txv_q) begin
            sh_q     <= txb_q;
            sda_oe_q <= ~txb_q[BYTE_W-1];
            txv_q    <= 1'b0;
            cnt_q    <= '0;
            state_q  <= S_RD_BITS;
          end
          S_RD_BITS: if (fall_i) begin
            if (cnt_q == CNT_LAST) begin
              sda_oe_q <= 1'b0;
              cnt_q    <= '0;
              state_q  <= S_RD_ACK;
            end else begin
              sda_oe_q <= ~sh_q[BYTE_W-2];
              sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          S_RD_ACK: begin
            if (rise_i) begin
              nak_q <= sda_f_i;
              if (sda_f_i) set_q[F_TX_NAK] <= 1'b1;
              else         set_q[F_TX_ACK] <= 1'b1;
            end else if (fall_i) begin
              state_q <= nak_q ? S_IGNORE : S_RD_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // clock hold is registered so released data leads the SCL release by a cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_oe_q <= 1'b0;
    else scl_oe_q <= en_i && !start_i && !stop_i &&
                     ((state_q == S_RD_WAIT) || (state_q == S_WR_WAIT && rx_pend_i));
  end

  assign scl_oe_o  = scl_oe_q;
  assign sda_oe_o  = sda_oe_q;
  assign set_o     = set_q;
  assign rx_data_o = rx_q;
  assign active_o  = act_q;

  // R1: a match event coincides with the address acknowledge
  p_ack_on_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_q[F_MATCH] |-> sda_oe_q);
  // R2: an unaddressed transfer raises no flag
  p_ignore_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IGNORE && !act_q) |=> (set_q == '0));
  // R4: SCL hold only ever starts while SCL is already low
  p_stretch_from_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_q) |-> !scl_f_i);
  // R5: driven SDA never moves while SCL is high
  p_sda_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f_i && $past(scl_f_i) && en_i && $past(en_i) && !$past(start_i) && !$past(stop_i))
      |-> $stable(sda_oe_q));
  // R6: a NAK leaves SDA released
  p_nak_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD_ACK && fall_i && nak_q && en_i && !start_i && !stop_i) |=> !sda_oe_q);
  // R9: disabled engine is silent
  p_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (set_q == '0 && !sda_oe_q && !scl_oe_q));
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgt_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_cmd_i,
  input  logic [STS_W-1:0]  sts_clr_i,
  output logic [STS_W-1:0]  sts_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              irq_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_f;
  logic start, stop, rise, fall, active;
  logic [STS_W-1:0] set_v, sts;

  assign line_raw = {sda_i, scl_i};

  for (genvar i = 0; i < N_LINES; i++) begin : g_filt
    i2c_tgt_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[i]),
      .q_o   (line_f[i])
    );
  end

  i2c_tgt_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (line_f[0]),
    .sda_i  (line_f[1]),
    .start_o(start),
    .stop_o (stop),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2c_tgt_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tgt_en_i),
    .own_addr_i(own_addr_i),
    .scl_f_i   (line_f[0]),
    .sda_f_i   (line_f[1]),
    .start_i   (start),
    .stop_i    (stop),
    .rise_i    (rise),
    .fall_i    (fall),
    .rx_pend_i (sts[F_RX_DONE]),
    .tx_cmd_i  (tx_cmd_i),
    .tx_data_i (tx_data_i),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .set_o     (set_v),
    .rx_data_o (rx_data_o),
    .active_o  (active)
  );

  i2c_tgt_flags u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (sts_clr_i),
    .sts_o (sts)
  );

  assign sts_o = sts;
  assign irq_o = |sts;

  // R7: a STOP closing an addressed transfer shows in the flags two cycles on
  p_stop_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && active && tgt_en_i) |-> ##2 sts_o[F_STOP]);
endmodule

// File: tb/i2c_tgt_engine_test.sv
module i2c_tgt_engine_test;
  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, tgt_en, tx_cmd, tb_scl_low, tb_sda_low;
  logic [6:0] own_addr;
  logic [7:0] tx_data, sts_clr, sts, rx_data;
  logic       scl_oe, sda_oe, irq;
  logic       scl_line, sda_line;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  assign scl_line = !(tb_scl_low | scl_oe);
  assign sda_line = !(tb_sda_low | sda_oe);

  i2c_tgt_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .tgt_en_i(tgt_en), .own_addr_i(own_addr),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .tx_data_i(tx_data), .tx_cmd_i(tx_cmd), .sts_clr_i(sts_clr),
    .sts_o(sts), .rx_data_o(rx_data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_clear(input logic [7:0] m);
    sts_clr = m; tick(1); sts_clr = '0; tick(1);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    tb_sda_low = 0; tb_scl_low = 0; tick(H);
    tb_sda_low = 1; tick(H);
    tb_scl_low = 1; tick(H);
  endtask

  task automatic bus_rstart();
    tb_sda_low = 0; tick(H);
    tb_scl_low = 0; wait_scl_high(); tick(H);
    tb_sda_low = 1; tick(H);
    tb_scl_low = 1; tick(H);
  endtask

  task automatic bus_stop();
    tb_sda_low = 1; tick(H);
    tb_scl_low = 0; wait_scl_high(); tick(H);
    tb_sda_low = 0; tick(H);
  endtask

  // hook 1: expect SCL held, then clear RX/match; hook 2: expect held, then load byte
  task automatic bit_xfer(input logic b, input int hook, input logic [7:0] txd,
                          input string req, output logic s);
    tb_sda_low = !b; tick(4);
    tb_scl_low = 0;
    if (hook != 0) begin
      tick(30);
      chk(req, scl_line, 1'b0);
      if (hook == 1) sw_clear(8'h84);
      else begin
        tx_data = txd; tx_cmd = 1; tick(1); tx_cmd = 0;
      end
    end
    wait_scl_high(); tick(H);
    s = sda_line;
    tb_scl_low = 1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input int hook, input string req,
                           output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], (i == 7) ? hook : 0, 8'h00, req, s);
    bit_xfer(1'b1, 0, 8'h00, req, ack);
  endtask

  task automatic recv_byte(input logic [7:0] txd, input logic cack, input string req,
                           output logic [7:0] got);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, (i == 7) ? 2 : 0, txd, req, s);
      got[i] = s;
    end
    bit_xfer(!cack, 0, 8'h00, req, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] got, d;
    rst_n = 0; tgt_en = 1; own_addr = OWN; tx_cmd = 0; tx_data = 0; sts_clr = 0;
    tb_scl_low = 0; tb_sda_low = 0;
    tick(5);
    chk("R11 flags", sts, 8'h00);
    chk("R11 scl", scl_oe, 1'b0);
    chk("R11 sda", sda_oe, 1'b0);
    chk("R11 irq", irq, 1'b0);
    rst_n = 1; tick(10);

    // write transfer: R1, R3, R4, R7
    bus_start();
    send_byte({OWN, 1'b0}, 0, "R1", ack);
    chk("R1 ack", ack, 1'b0);
    chk("R1 flags", sts, 8'h84);
    chk("R1 rx", rx_data, {OWN, 1'b0});
    chk("R10 irq", irq, 1'b1);
    for (int k = 0; k < 6; k++) begin
      d = 8'((k * 37 + 5) & 255);
      send_byte(d, 1, "R4 hold", ack);
      chk("R3 ack", ack, 1'b0);
      chk("R3 rx", rx_data, d);
      chk("R3 flags", sts, 8'h04);
    end
    chk("R4 hold pending", scl_oe, 1'b1);
    sw_clear(8'h04); tick(3);
    chk("R4 release", scl_oe, 1'b0);
    bus_stop();
    chk("R7 stop", sts, 8'h10);
    sw_clear(8'hff);
    chk("R10 clear", sts, 8'h00);

    // read transfer: R5, R6
    bus_start();
    send_byte({OWN, 1'b1}, 0, "R5", ack);
    chk("R1 read ack", ack, 1'b0);
    chk("R1 rx rw", rx_data, {OWN, 1'b1});
    sw_clear(8'hff);
    for (int k = 0; k < 4; k++) begin
      d = 8'((k * 73 + 60) & 255);
      recv_byte(d, k != 3, "R5 hold", got);
      chk("R5 data", got, d);
      chk("R6 flag", sts, (k != 3) ? 8'h01 : 8'h02);
      sw_clear(8'hff);
    end
    tick(40);
    chk("R6 sda free", sda_oe, 1'b0);
    chk("R6 no hold", scl_oe, 1'b0);
    bus_stop();
    chk("R7 stop read", sts, 8'h10);
    sw_clear(8'hff);

    // W1C per bit: R10
    bus_start();
    send_byte({OWN, 1'b0}, 0, "R10", ack);
    sw_clear(8'h80);
    chk("R10 partial", sts, 8'h04);
    sw_clear(8'h04);
    bus_stop();
    sw_clear(8'hff);

    // full address sweep: R1, R2
    for (int a = 0; a < 128; a++) begin
      bit m;
      m = (a == int'(OWN));
      bus_start();
      send_byte({7'(a), 1'b0}, 0, "R2", ack);
      chk("R2 ack", ack, !m);
      chk("R2 flags", sts, m ? 8'h84 : 8'h00);
      chk("R2 hold", scl_oe, m);
      if (m) sw_clear(8'h84);
      bus_stop();
      chk("R2 stop", sts, m ? 8'h10 : 8'h00);
      sw_clear(8'hff);
    end

    // repeated start: R8
    bus_start();
    send_byte({OWN ^ 7'h01, 1'b0}, 0, "R8", ack);
    chk("R8 other", ack, 1'b1);
    bus_rstart();
    send_byte({OWN, 1'b0}, 0, "R8", ack);
    chk("R8 own", ack, 1'b0);
    chk("R8 flags", sts, 8'h84);
    sw_clear(8'h84);
    bus_rstart();
    send_byte({OWN ^ 7'h40, 1'b0}, 0, "R8", ack);
    chk("R8 other again", ack, 1'b1);
    bus_stop();
    chk("R8 stop", sts, 8'h00);

    // disabled: R9
    tgt_en = 0; tick(4);
    bus_start();
    send_byte({OWN, 1'b0}, 0, "R9", ack);
    chk("R9 ack", ack, 1'b1);
    chk("R9 flags", sts, 8'h00);
    bus_stop();
    chk("R9 stop", sts, 8'h00);
    tgt_en = 1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule